// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block recovers 32-bit words from a two-wire return-to-zero serial line. The line reaches it already translated to logic levels as two signals, one for the high state and one for the low state. A reference tick, an enable pulse in the system clock domain taken from the reference clock chosen for the channel, sets the time base. A bit lasts 10 ticks at high speed and 80 ticks at low speed.

Each bit begins with a pulse on exactly one of the two wires. The receiver finds the leading edge of each pulse and samples the wires a quarter of a bit time later. It shifts the decoded bits into a word. After 32 bits and one bit time of null, it presents the word with a one-cycle valid strobe and an odd-parity flag. A long null restarts word assembly. An invert input swaps the roles of the two wires, so that looped-back inverted data from a wraparound test decodes correctly.

Top module: `a429_rx`

## Requirements
- R1: While reset is asserted and after it is released, `word_o`, `word_valid_o` and `parity_err_o` read zero until the first word is delivered.
- R2: A pulse on `line_hi_i` alone is a one and a pulse on `line_lo_i` alone is a zero. The first bit received lands in `word_o[0]` and the 32nd bit, which is the parity bit, lands in `word_o[31]`.
- R3: Timing advances only on cycles with `ref_tick` high. A bit is 10 ticks with `speed_lo` low and 80 ticks with `speed_lo` high. Words decode correctly when the actual bit period is anywhere within 5% of nominal.
- R4: A bit value is taken from the line state a quarter of a bit time (integer ticks) after the tick on which the pulse's leading edge is seen. A pulse that lasts at least that long decodes, and one that has already ended by then is treated as invalid.
- R5: `word_valid_o` is high for exactly one cycle per delivered word, after 32 bits have been received and two bit times have passed since the last leading edge. `word_o` changes only in that cycle and holds its value otherwise.
- R6: `parity_err_o` is 1 when the delivered word holds an even number of ones and 0 when it holds an odd number. Words with a parity error are still delivered.
- R7: If the sampled line state of any bit is anything other than exactly one wire active, the whole word is discarded and no valid strobe is produced for it.
- R8: A leading edge arriving more than three bit times after the previous one, that is after more than two bit times of null, discards any partial word and starts a new one. A shorter pause mid-word does not interrupt assembly.
- R9: With `invert` high, the two wires swap roles: a pulse on `line_lo_i` is a one and a pulse on `line_hi_i` is a zero.
- R10: A 33rd bit arriving without an intervening word end or restart causes that word to be discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| speed_lo | input | 1 | 1 selects low speed (80 ticks per bit), 0 selects high speed (10 ticks per bit) |
| invert | input | 1 | Swap the meaning of the two line wires (wraparound test) |
| line_hi_i | input | 1 | Line in the high state (asynchronous) |
| line_lo_i | input | 1 | Line in the low state (asynchronous) |
| word_o | output | WORD_BITS | Last delivered word, first received bit in bit 0 |
| word_valid_o | output | 1 | One-cycle strobe when a new word is on `word_o` |
| parity_err_o | output | 1 | Even number of ones in the delivered word |

## Verification
The bench builds the block with its default parameters: 10 and 80 ticks per bit, 32-bit words and a two-stage synchronizer. Setting the tick period to one and then two system cycles makes bit periods of 19, 20 and 21 cycles possible at high speed, and 76 and 84 cycles at low speed, so the ±5% limits can be reached with whole-cycle stimulus. The quarter-bit sample point at high speed is only two ticks, so a four-cycle pulse and a one-cycle pulse fall on either side of it.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    typedef enum logic [1:0] {
        SYM_NULL = 2'd0,
        SYM_ZERO = 2'd1,
        SYM_ONE  = 2'd2,
        SYM_BAD  = 2'd3
    } sym_e;

    // Map the two synchronized wires to a line symbol.
    function automatic sym_e classify(input logic hi, input logic lo);
        sym_e s;
        case ({hi, lo})
            2'b10:   s = SYM_ONE;
            2'b01:   s = SYM_ZERO;
            2'b11:   s = SYM_BAD;
            default: s = SYM_NULL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/a429_rx_front.sv
module a429_rx_front
    import a429_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic invert,
    input  logic line_hi_i,
    input  logic line_lo_i,
    output sym_e sym
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][1:0] pipe;
    } front_s;

    front_s st_d, st_q;
    logic [1:0] pair;

    always_comb begin
        // Swap the wires ahead of the synchronizer in wraparound mode.
        pair = invert ? {line_lo_i, line_hi_i} : {line_hi_i, line_lo_i};
        st_d = st_q;
        st_d.pipe[0] = pair;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sym = classify(st_q.pipe[SYNC_STAGES-1][1], st_q.pipe[SYNC_STAGES-1][0]);

endmodule

// File: rtl/a429_rx_timer.sv
module a429_rx_timer
    import a429_rx_pkg::*;
#(
    parameter int HS_DIV = 10,
    parameter int LS_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic speed_lo,
    input  sym_e sym,
    output logic bit_stb,
    output logic bit_one,
    output logic bit_bad,
    output logic restart,
    output logic null_stb
);

    localparam int MAXDIV = (LS_DIV > HS_DIV) ? LS_DIV : HS_DIV;
    localparam int SAT    = 4 * MAXDIV;
    localparam int CW     = $clog2(SAT + 1);

    typedef struct packed {
        logic          prev_act;
        logic [CW-1:0] since;
        logic          bit_stb;
        logic          bit_one;
        logic          bit_bad;
        logic          restart;
        logic          null_stb;
    } tmr_s;

    tmr_s st_d, st_q;
    logic [CW-1:0] div, quarter, two_bits, three_bits;
    logic act;

    always_comb begin
        div        = speed_lo ? CW'(LS_DIV) : CW'(HS_DIV);
        quarter    = div >> 2;
        two_bits   = div << 1;
        three_bits = two_bits + div;
        act        = (sym != SYM_NULL);

        st_d          = st_q;
        st_d.bit_stb  = 1'b0;
        st_d.restart  = 1'b0;
        st_d.null_stb = 1'b0;

        if (tick) begin
            st_d.prev_act = act;
            if (act && !st_q.prev_act) begin
                // Leading edge: measure the spacing from the previous one.
                st_d.since   = CW'(1);
                st_d.restart = (st_q.since > three_bits);
            end else begin
                if (st_q.since < CW'(SAT)) begin
                    st_d.since = st_q.since + CW'(1);
                end
                if (st_q.since == quarter) begin
                    st_d.bit_stb = 1'b1;
                    st_d.bit_one = (sym == SYM_ONE);
                    st_d.bit_bad = (sym != SYM_ONE) && (sym != SYM_ZERO);
                end
                if (st_q.since == two_bits) begin
                    st_d.null_stb = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.since <= CW'(SAT);
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_stb  = st_q.bit_stb;
    assign bit_one  = st_q.bit_one;
    assign bit_bad  = st_q.bit_bad;
    assign restart  = st_q.restart;
    assign null_stb = st_q.null_stb;

    // R4: sampling and end-of-word detection never coincide
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.bit_stb && st_q.null_stb));

    // R8: a restart is only raised together with a fresh edge count
    a_r8_restart_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.restart |-> (st_q.since == CW'(1)));

endmodule

// File: rtl/a429_rx_word.sv
module a429_rx_word #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 bit_one,
    input  logic                 bit_bad,
    input  logic                 restart,
    input  logic                 null_stb,
    output logic [WORD_BITS-1:0] word,
    output logic                 valid,
    output logic                 parity_err
);

    localparam int CNTW = $clog2(WORD_BITS + 1);

    typedef struct packed {
        logic [WORD_BITS-1:0] sh;
        logic [CNTW-1:0]      cnt;
        logic                 err;
        logic [WORD_BITS-1:0] word;
        logic                 valid;
        logic                 perr;
    } asm_s;

    asm_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else if (bit_stb) begin
            if (st_q.cnt == CNTW'(WORD_BITS)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.sh  = {bit_one, st_q.sh[WORD_BITS-1:1]};
                st_d.cnt = st_q.cnt + CNTW'(1);
            end
            if (bit_bad) begin
                st_d.err = 1'b1;
            end
        end else if (null_stb && (st_q.cnt == CNTW'(WORD_BITS))) begin
            if (!st_q.err) begin
                st_d.word  = st_q.sh;
                st_d.valid = 1'b1;
                st_d.perr  = ~^st_q.sh;
            end
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word       = st_q.word;
    assign valid      = st_q.valid;
    assign parity_err = st_q.perr;

    // R10: the bit count never runs past one word
    a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNTW'(WORD_BITS));

    // R8: a restart leaves an empty word behind
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/a429_rx.sv
module a429_rx #(
    parameter int HS_DIV      = 10,
    parameter int LS_DIV      = 80,
    parameter int WORD_BITS   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_tick,
    input  logic                 speed_lo,
    input  logic                 invert,
    input  logic                 line_hi_i,
    input  logic                 line_lo_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_valid_o,
    output logic                 parity_err_o
);

    a429_rx_pkg::sym_e sym;
    logic bit_stb, bit_one, bit_bad, restart, null_stb;

    a429_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .invert    (invert),
        .line_hi_i (line_hi_i),
        .line_lo_i (line_lo_i),
        .sym       (sym)
    );

    a429_rx_timer #(.HS_DIV(HS_DIV), .LS_DIV(LS_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ref_tick),
        .speed_lo (speed_lo),
        .sym      (sym),
        .bit_stb  (bit_stb),
        .bit_one  (bit_one),
        .bit_bad  (bit_bad),
        .restart  (restart),
        .null_stb (null_stb)
    );

    a429_rx_word #(.WORD_BITS(WORD_BITS)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_one    (bit_one),
        .bit_bad    (bit_bad),
        .restart    (restart),
        .null_stb   (null_stb),
        .word       (word_o),
        .valid      (word_valid_o),
        .parity_err (parity_err_o)
    );

    // R5: the valid strobe lasts a single cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    // R5: the delivered word only moves with the strobe
    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_o));

endmodule

// File: tb/a429_rx_tb.sv
module a429_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        speed_lo = 1'b0;
    logic        invert = 1'b0;
    logic        line_hi_i = 1'b0;
    logic        line_lo_i = 1'b0;
    logic [31:0] word_o;
    logic        word_valid_o;
    logic        parity_err_o;

    int checks = 0;
    int failures = 0;
    int tick_div = 1;
    int tick_ph = 0;
    string cur_req = "R2";
    logic [31:0] exp_word_q[$];
    logic        exp_perr_q[$];
    logic [31:0] last_word = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    a429_rx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick     (ref_tick),
        .speed_lo     (speed_lo),
        .invert       (invert),
        .line_hi_i    (line_hi_i),
        .line_lo_i    (line_lo_i),
        .word_o       (word_o),
        .word_valid_o (word_valid_o),
        .parity_err_o (parity_err_o)
    );

    task automatic check(string req, bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model: every clock, a strobe must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && word_valid_o) begin
            if (exp_word_q.size() == 0) begin
                check(cur_req, 1'b0, "unexpected word strobe", word_o, 32'h0);
            end else begin
                check(cur_req, word_o == exp_word_q[0], "word value", word_o, exp_word_q[0]);
                check("R6", parity_err_o == exp_perr_q[0], "parity flag",
                      {31'h0, parity_err_o}, {31'h0, exp_perr_q[0]});
                last_word = exp_word_q[0];
                void'(exp_word_q.pop_front());
                void'(exp_perr_q.pop_front());
            end
        end
    end

    task automatic step(logic hi, logic lo);
        @(negedge clk);
        line_hi_i = invert ? lo : hi;
        line_lo_i = invert ? hi : lo;
        tick_ph++;
        ref_tick = ((tick_ph % tick_div) == 0);
    endtask

    // One bit: active for 'width' cycles of a 'per'-cycle period; bad drives both wires.
    task automatic send_bit(logic v, int per, int width, bit bad);
        for (int c = 0; c < per; c++) begin
            if (c < width) step(v | bad, ~v | bad);
            else           step(1'b0, 1'b0);
        end
    endtask

    task automatic send_null(int cyc);
        for (int c = 0; c < cyc; c++) step(1'b0, 1'b0);
    endtask

    task automatic expect_word(logic [31:0] w);
        exp_word_q.push_back(w);
        exp_perr_q.push_back(($countones(w) % 2) == 0);
    endtask

    // nbits bits of w; bit bad_idx is malformed (bad or short) when >= 0.
    task automatic send_word(logic [31:0] w, int per, int nbits, int bad_idx,
                             bit short_bad, int pause_idx, int pulse_w);
        for (int i = 0; i < nbits; i++) begin
            if (i == bad_idx && short_bad)  send_bit(w[i % 32], per, 1, 1'b0);
            else if (i == bad_idx)          send_bit(w[i % 32], per, per / 2, 1'b1);
            else                            send_bit(w[i % 32], per, pulse_w, 1'b0);
            if (i == pause_idx) send_null(per);
        end
    endtask

    task automatic drain(string req, int per);
        send_null(5 * per);
        check(req, exp_word_q.size() == 0, "expected word not delivered",
              exp_word_q.size(), 0);
        check("R5", word_o == last_word, "word holds after strobe", word_o, last_word);
    endtask

    task automatic good_word(string req, logic [31:0] w, int per);
        cur_req = req;
        expect_word(w);
        send_word(w, per, 32, -1, 1'b0, -1, per / 2);
        drain(req, per);
    endtask

    initial begin
        repeat (4) step(1'b0, 1'b0);
        check("R1", word_o == 32'h0, "word in reset", word_o, 32'h0);
        check("R1", word_valid_o == 1'b0, "valid in reset", {31'h0, word_valid_o}, 32'h0);
        rst_n = 1'b1;
        send_null(40);
        check("R1", word_o == 32'h0 && !word_valid_o && !parity_err_o,
              "idle after reset", word_o, 32'h0);

        // R2 bit mapping and ordering, R6 parity, high speed nominal
        good_word("R2", 32'h0000_0001, 10);
        good_word("R2", 32'h8000_0000, 10);
        good_word("R2", 32'hA5C3_1E87, 10);
        good_word("R6", 32'hFFFF_FFFF, 10);
        good_word("R6", 32'h1234_5678, 10);

        // R3 gated ticks: 20-cycle nominal, 19 and 21 cycles at +/-5%
        tick_div = 2;
        good_word("R3", 32'h5A5A_0F0F, 20);
        good_word("R3", 32'hC0DE_0001, 19);
        good_word("R3", 32'h0BAD_F00D, 21);
        tick_div = 1;

        // R3 low speed at the 5% limits
        speed_lo = 1'b1;
        send_null(400);
        good_word("R3", 32'h7E81_3C24, 76);
        good_word("R3", 32'h0123_4567, 84);
        speed_lo = 1'b0;
        send_null(100);

        // R4 narrow pulse covering the sample point decodes
        cur_req = "R4";
        expect_word(32'h3333_CCCC);
        send_word(32'h3333_CCCC, 10, 32, -1, 1'b0, -1, 4);
        drain("R4", 10);
        // R4 pulse gone by the sample point discards the word
        send_word(32'h1111_1111, 10, 32, 7, 1'b1, -1, 5);
        drain("R4", 10);

        // R7 both wires active at sample time discards the word
        cur_req = "R7";
        send_word(32'h2222_2222, 10, 32, 5, 1'b0, -1, 5);
        drain("R7", 10);

        // R8 partial word then long pause, then a full word
        cur_req = "R8";
        send_word(32'hFFFF_FFFF, 10, 10, -1, 1'b0, -1, 5);
        send_null(30);
        expect_word(32'h4444_8888);
        send_word(32'h4444_8888, 10, 32, -1, 1'b0, -1, 5);
        drain("R8", 10);
        // R8 short mid-word pause keeps the word together
        expect_word(32'h9876_5432);
        send_word(32'h9876_5432, 10, 32, -1, 1'b0, 15, 5);
        drain("R8", 10);

        // R9 wraparound with swapped wires
        invert = 1'b1;
        good_word("R9", 32'hDEAD_BEEF, 10);
        invert = 1'b0;
        send_null(20);

        // R10 a 33rd bit discards the word
        cur_req = "R10";
        send_word(32'h0F0F_0F0F, 10, 33, -1, 1'b0, -1, 5);
        drain("R10", 10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule